// File: doc/BRIEF.md
# Down-Counting Interval Timer

A single-channel down counter behind a small word-wide register bus. Software programs an interval, picks a tick source and a power-of-two prescale, and starts the counter. Every prescaled tick moves the count down by one. When a step takes the count from one to zero, a pending flag is raised, and a level interrupt follows while that flag is pending and the interrupt enable is set.

In auto-reload mode the counter takes the interval value on the step after it reaches zero, so it produces a steady train of expiries. In single-shot mode the counter stops at zero by clearing its own run bit. Software can overwrite the current count at any time to move the next expiry point. Software clears the pending flag by writing a one to it.

Top module: `itmr_top`

## Requirements
- R1: Byte offsets: 0x00 interrupt enable (bit 0), 0x04 pending status (bit 0), 0x10 control (bits 6:0, higher bits read 0), 0x14 interval, 0x18 current count. A read returns data on `bus_rdata` one cycle after the request. Unmapped offsets read 0. Every register resets to 0.
- R2: Control bit 0 is the run bit. While it is clear the count holds its value.
- R3: Control bits 3:2 select which bit of `src_ticks` feeds the prescaler. Code 1 is the high-frequency oscillator input.
- R4: With control bits 6:4 equal to n (0..7), the count takes one step per 2^n selected ticks. The divider restarts when the run bit is clear, so the first step comes on the 2^n-th tick after the timer starts.
- R5: A step from count 1 to 0 is an expiry. It sets the pending flag on the same clock edge.
- R6: With control bit 1 set (auto-reload), a step at count 0 loads the interval register. The steady period is interval+1 steps.
- R7: With control bit 1 clear (single-shot), an expiry clears the run bit in hardware and the count stays at 0.
- R8: In single-shot mode, a step at count 0 (after software has set the count to 0) wraps the count to all ones and raises no expiry.
- R9: A write to the current-count register sets the count. The write takes precedence over a step in the same cycle.
- R10: Writing 1 to status bit 0 clears the pending flag. Writing 0 leaves it unchanged.
- R11: When a clearing write and an expiry fall in the same cycle, the flag stays set.
- R12: `irq_out` equals (pending AND enable bit 0), registered one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| src_ticks | input | 4 | Tick enables, one per source code |
| irq_out | output | 1 | Level interrupt request |

## Verification
The bench builds the timer with an 8-bit data path. This keeps the wrap from zero to all ones, and full reload periods, within a few cycles. It sweeps all eight prescale codes at the tick counts just below, at, and past each divide boundary. Auto-reload and single-shot runs are checked over every stop point of a few periods against an arithmetic step model. Edge collisions are placed on exact cycles: clear against expiry, and a count write against a step.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int OFS_IEN  = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_CTRL = 'h10;
  localparam int OFS_IVAL = 'h14;
  localparam int OFS_CUR  = 'h18;
  localparam int CTRL_W   = 7;

  typedef struct packed {
    logic [2:0] presc;
    logic [1:0] src;
    logic       reload;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int CODE_W = 3,
  parameter int SRC_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic [SRC_W-1:0]      src_sel,
  input  logic [CODE_W-1:0]     code,
  input  logic [2**SRC_W-1:0]   src_ticks,
  output logic                  step
);
  localparam int DIV_W = 2**CODE_W - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             tick;

  assign tick = src_ticks[src_sel];
  assign mask = ~({DIV_W{1'b1}} << code);
  assign step = run & tick & ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else if (tick)   div_q <= div_q + 1'b1;
  end

  // R4: divider idles at zero whenever the run bit is clear
  assert_div_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> div_q == '0);
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              reload_mode,
  input  logic [DATA_W-1:0] interval,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cnt,
  output logic              expire
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cnt_q;

  assign cnt    = cnt_q;
  assign expire = step & !wr_en & (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst)                               cnt_q <= '0;
    else if (wr_en)                        cnt_q <= wr_data;
    else if (step && cnt_q == '0 && reload_mode) cnt_q <= interval;
    else if (step)                         cnt_q <= cnt_q - 1'b1;
  end

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_en && cnt_q == '0 && reload_mode) |=> cnt_q == $past(interval));
  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_en && cnt_q == '0 && !reload_mode) |=> &cnt_q);
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cnt_q == $past(wr_data));
endmodule

// File: rtl/itmr_irq.sv
module itmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr,
  input  logic ien,
  output logic pend,
  output logic irq
);
  logic pend_q, irq_q;

  assign pend = pend_q;
  assign irq  = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (expire)   pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
      irq_q <= pend_q & ien;
    end
  end

  // R5 and R11: an expiry always leaves the flag set, clear or not
  assert_expiry_sets_R5: assert property (@(posedge clk) disable iff (rst)
    expire |=> pend_q);
  assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
    (clr && !expire) |=> !pend_q);
  assert_irq_gate_R12: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(pend_q && ien));
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [3:0]        src_ticks,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_IVAL = ADDR_W'(OFS_IVAL);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFS_CUR);

  ctrl_t             ctrl_q;
  logic              ien_q;
  logic [DATA_W-1:0] ival_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] cnt;
  logic              step, expire, pend;
  logic              wr, rd;
  logic              wr_ien, wr_stat, wr_ctrl, wr_ival, wr_cur;

  assign wr      = bus_sel & bus_wr;
  assign rd      = bus_sel & !bus_wr;
  assign wr_ien  = wr & (bus_addr == A_IEN);
  assign wr_stat = wr & (bus_addr == A_STAT);
  assign wr_ctrl = wr & (bus_addr == A_CTRL);
  assign wr_ival = wr & (bus_addr == A_IVAL);
  assign wr_cur  = wr & (bus_addr == A_CUR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ien_q  <= 1'b0;
      ival_q <= '0;
    end else begin
      if (wr_ien)  ien_q  <= bus_wdata[0];
      if (wr_ival) ival_q <= bus_wdata;
      if (wr_ctrl)                        ctrl_q     <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      else if (expire && !ctrl_q.reload)  ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd) begin
      case (bus_addr)
        A_IEN:   rdata_q <= DATA_W'(ien_q);
        A_STAT:  rdata_q <= DATA_W'(pend);
        A_CTRL:  rdata_q <= DATA_W'(ctrl_q);
        A_IVAL:  rdata_q <= ival_q;
        A_CUR:   rdata_q <= cnt;
        default: rdata_q <= '0;
      endcase
    end
  end
  assign bus_rdata = rdata_q;

  itmr_prescaler #(.CODE_W(3), .SRC_W(2)) u_presc (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .src_sel(ctrl_q.src),
    .code(ctrl_q.presc), .src_ticks(src_ticks), .step(step)
  );

  itmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .reload_mode(ctrl_q.reload),
    .interval(ival_q), .wr_en(wr_cur), .wr_data(bus_wdata),
    .cnt(cnt), .expire(expire)
  );

  itmr_irq u_irq (
    .clk(clk), .rst(rst), .expire(expire), .clr(wr_stat & bus_wdata[0]),
    .ien(ien_q), .pend(pend), .irq(irq_out)
  );

  assert_halt_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !wr_cur) |=> $stable(cnt));
  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (expire && !ctrl_q.reload && !wr_ctrl) |=> (!ctrl_q.run && cnt == '0));
endmodule

// File: tb/itmr_top_tb_top.sv
module itmr_top_tb_top;
  localparam int DW   = 8;
  localparam int AW   = 5;
  localparam int MASK = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [3:0]    src_ticks = 4'b0010;
  logic          irq_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  itmr_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_ticks(src_ticks), .irq_out(irq_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
    @(negedge clk);
    bus_sel = 0;
    d = int'(bus_rdata);
  endtask

  function automatic void model(input int start, input int ival, input int steps,
                                input bit rl, output int val, output bit ex);
    int c = start;
    bit go = 1;
    ex = 0;
    for (int i = 0; i < steps; i++) begin
      if (go) begin
        if (c == 0) c = rl ? ival : MASK;
        else begin
          if (c == 1) begin ex = 1; if (!rl) go = 0; end
          c = c - 1;
        end
      end
    end
    val = c;
  endfunction

  // start at 'start', run with control word 'cw' for w+1 edges, stop, read back
  task automatic run(input int start, input int cw, input int w, output int val, output int st);
    wr('h18, start);
    wr('h04, 1);
    wr('h10, cw);
    repeat (w) @(negedge clk);
    wr('h10, cw & 'h7E);
    rd('h18, val);
    rd('h04, st);
  endtask

  initial begin
    int v, s, e, v2;
    bit ex;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset values and map
    check("R1 irq reset", int'(irq_out), 0);
    rd('h00, v); check("R1 ien reset", v, 0);
    rd('h04, v); check("R1 stat reset", v, 0);
    rd('h10, v); check("R1 ctrl reset", v, 0);
    rd('h14, v); check("R1 ival reset", v, 0);
    rd('h18, v); check("R1 cur reset", v, 0);
    wr('h14, 'hA5); rd('h14, v); check("R1 ival readback", v, 'hA5);
    wr('h10, 'hF2); rd('h10, v); check("R1 ctrl bit7 reads 0", v, 'h72);
    wr('h10, 0);
    rd('h08, v); check("R1 unmapped", v, 0);

    // R4 prescale sweep, source 1 ticking every cycle
    for (int n = 0; n < 8; n++) begin
      for (int k = 0; k < 3; k++) begin
        int w = (k == 0) ? (1 << n) - 2 : (k == 1) ? (1 << n) - 1 : 3 * (1 << n) - 1;
        if (w >= 0) begin
          run(200, (n << 4) | 'h05, w, v, s);
          check($sformatf("R4 code %0d wait %0d", n, w), v, 200 - ((w + 1) >> n));
        end
      end
    end

    // R3 source 0 idle, R2 halt holds
    run(90, 'h01, 20, v, s);
    check("R3 source 0 no steps", v, 90);
    run(90, 'h05, 4, v, s);
    repeat (10) @(negedge clk);
    rd('h18, v2);
    check("R2 halted count holds", v2, v);
    check("R2 count before halt", v, 85);

    // R6 auto-reload sweep: interval 4, start 2
    wr('h14, 4);
    for (int w = 0; w < 13; w++) begin
      run(2, 'h07, w, v, s);
      model(2, 4, w + 1, 1, e, ex);
      check($sformatf("R6 reload value wait %0d", w), v, e);
      check($sformatf("R5 reload pend wait %0d", w), s, int'(ex));
    end

    // R7 single-shot sweep: start 3
    for (int w = 0; w < 7; w++) begin
      run(3, 'h05, w, v, s);
      model(3, 4, w + 1, 0, e, ex);
      check($sformatf("R7 oneshot value wait %0d", w), v, e);
      check($sformatf("R5 oneshot pend wait %0d", w), s, int'(ex));
    end

    // R8 wrap from zero in single-shot
    for (int t = 1; t <= 3; t++) begin
      run(0, 'h05, t - 1, v, s);
      check($sformatf("R8 wrap steps %0d", t), v, MASK + 1 - t);
      check($sformatf("R8 no expiry steps %0d", t), s, 0);
    end

    // R9 write beats step: write 50 while running, stop next edge
    wr('h18, 200);
    wr('h10, 'h05);
    repeat (3) @(negedge clk);
    wr('h18, 50);
    wr('h10, 'h04);
    rd('h18, v);
    check("R9 write wins then one step", v, 49);

    // R5/R7/R12 exact expiry timing
    wr('h00, 1);
    wr('h18, 3);
    wr('h04, 1);
    wr('h10, 'h05);
    repeat (3) @(negedge clk);
    check("R12 irq low before expiry", int'(irq_out), 0);
    @(negedge clk);
    check("R12 irq one cycle after expiry", int'(irq_out), 1);
    rd('h10, v); check("R7 run bit cleared", v, 'h04);
    rd('h18, v); check("R7 count held at 0", v, 0);
    wr('h00, 0);
    @(negedge clk);
    check("R12 enable off masks irq", int'(irq_out), 0);
    wr('h00, 1);
    @(negedge clk);
    check("R12 enable on restores irq", int'(irq_out), 1);
    wr('h04, 0);
    rd('h04, v); check("R10 write 0 no effect", v, 1);
    check("R10 irq still high", int'(irq_out), 1);
    wr('h04, 1);
    @(negedge clk);
    check("R10 irq drops after clear", int'(irq_out), 0);
    rd('h04, v); check("R10 cleared", v, 0);

    // R11 clear collides with expiry
    wr('h18, 1);
    wr('h10, 'h05);
    wr('h04, 1);
    rd('h04, v); check("R11 expiry beats clear", v, 1);
    wr('h04, 1);
    rd('h04, v); check("R11 later clear works", v, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule